// File: doc/BRIEF.md
# Dual-Channel Register Broadcast Front End

This block connects a plain CPU register bus to two identical serial-port register banks. Each access carries a 3-bit register address and a channel-select bit. The block steers a write to the bank that the select bit names. A read returns the value of the named bank's register on the following cycle. Both channels share one configuration register, which sits at a fixed address. One bit of that register turns on broadcast writes. With broadcast on, a single bus write lands in the same register of both banks, so two channels that need identical settings can be initialised in half the bus cycles. Reads still follow the channel-select bit while broadcast is on.

The same shared register also holds a two-bit source code. This code picks what each channel's multi-function output pin shows: the channel's OP2 interrupt-enable flag, its baud-rate clock, its receive-ready flag, or a constant low level. The banks are stubs. They hold plain storage registers and a scratchpad, and they derive those three per-channel signals from fixed register bits and from a small baud divider.

Register map, per channel, by address: 0 holds the receive-ready flag in bit 0. 1 holds the baud divisor. 4 holds the OP2 flag in bit 3. 5 is the shared configuration register. 7 is the scratchpad. Addresses 2, 3 and 6 are plain storage. In the shared register, bit 0 enables broadcast, bits 2:1 give the source code and bits 7:3 read as zero.

Top module: `dual_bcast_frontend`

## Requirements
- R1: After reset every bank register, the shared register, `rd_data` and both bits of `mf_out` are 0.
- R2: With broadcast off (shared register bit 0 = 0), a write with `cs` and `wr` high updates only the bank that `ch_sel` names (0 = channel A, 1 = channel B), at the rising clock edge.
- R3: With broadcast on (bit 0 = 1), a write to any address other than 5 updates that address in both banks, whatever the value of `ch_sel`.
- R4: A read with `cs` and `rd` high puts the addressed register of the bank that `ch_sel` names on `rd_data` one clock edge later, whether broadcast is on or off.
- R5: The shared register at address 5 is one register. A write to it through either channel is a single write and is not duplicated. A read through either channel returns it, with bits 7:3 always 0.
- R6: The scratchpad at address 7 stores 8 bits per channel and has no effect on `mf_out`.
- R7: With source code 00 (bits 2:1), `mf_out[c]` equals bit 3 of address 4 of channel c, where bit 0 of `mf_out` is channel A and bit 1 is channel B.
- R8: With source code 01, `mf_out[c]` is channel c's baud clock. This clock toggles once every (D+1) cycles, where D is the value at address 1 of that channel.
- R9: With source code 10, `mf_out[c]` equals bit 0 of address 0 of channel c.
- R10: With source code 11, both `mf_out` bits are 0.
- R11: A write strobe without `cs` changes no register, and a read strobe without `cs` leaves `rd_data` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs | input | 1 | Chip select |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| addr | input | 3 | Register address |
| ch_sel | input | 1 | Channel select, 0 = A, 1 = B |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| mf_out | output | 2 | Multi-function outputs, bit 0 = A, bit 1 = B |

## Verification
The hardest case to reach is proving that a broadcast write really reached the bank that `ch_sel` did not name. The only way to see that bank is a later read, and that read must be made with broadcast still on. The stimulus first loads different values into the two banks with broadcast off. It then enables broadcast through the channel-B alias of the shared register, writes through channel A, and reads both banks back. It also reads the pre-loaded registers to confirm that reads stay channel-selected. The baud source is checked by setting the divisor in both banks with a single broadcast write, then counting transitions on each pin over a fixed window of cycles.

// File: rtl/dbf_pkg.sv
package dbf_pkg;
    localparam int DATA_W_DEF = 8;
    localparam int ADDR_W_DEF = 3;
    localparam int NUM_CH     = 2;

    typedef enum logic [1:0] {
        MF_OP2   = 2'b00,
        MF_BAUD  = 2'b01,
        MF_RXRDY = 2'b10,
        MF_NONE  = 2'b11
    } mf_src_e;
endpackage

// File: rtl/dbf_chan_bank.sv
module dbf_chan_bank #(
    parameter int DATA_W   = 8,
    parameter int ADDR_W   = 3,
    parameter int RXF_ADDR = 0,
    parameter int DIV_ADDR = 1,
    parameter int OP2_ADDR = 4,
    parameter int OP2_BIT  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              op2,
    output logic              baud,
    output logic              rxrdy
);
    localparam int NREG = 1 << ADDR_W;

    typedef struct packed {
        logic [NREG-1:0][DATA_W-1:0] regs;
        logic [DATA_W-1:0]           cnt;
        logic                        baud;
    } bank_st_t;

    bank_st_t s_d, s_q;
    logic [DATA_W-1:0] div;

    assign div = s_q.regs[DIV_ADDR];

    always_comb begin
        s_d = s_q;
        if (we) begin
            s_d.regs[addr] = wdata;
        end
        if (s_q.cnt >= div) begin
            s_d.cnt  = '0;
            s_d.baud = ~s_q.baud;
        end else begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rdata = s_q.regs[addr];
    assign op2   = s_q.regs[OP2_ADDR][OP2_BIT];
    assign rxrdy = s_q.regs[RXF_ADDR][0];
    assign baud  = s_q.baud;

    // assertion support: marks cycles whose $past lies after reset
    logic live_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) live_q <= 1'b0;
        else        live_q <= 1'b1;
    end

    assert_hold_without_we_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(s_q.regs));

    assert_baud_div0_toggles_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && $past(div) == '0) |-> (baud != $past(baud)));
endmodule

// File: rtl/dbf_shared_cfg.sv
module dbf_shared_cfg #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output logic              bcast,
    output logic [1:0]        mf_src,
    output logic [DATA_W-1:0] rval
);
    typedef struct packed {
        logic [1:0] src;
        logic       bc;
    } cfg_st_t;

    cfg_st_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (we) begin
            c_d.bc  = wdata[0];
            c_d.src = wdata[2:1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign bcast  = c_q.bc;
    assign mf_src = c_q.src;
    assign rval   = {{(DATA_W-3){1'b0}}, c_q.src, c_q.bc};

    assert_cfg_takes_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (rval[2:0] == $past(wdata[2:0])));
endmodule

// File: rtl/dbf_mf_mux.sv
module dbf_mf_mux
    import dbf_pkg::*;
(
    input  logic [1:0] src,
    input  logic       op2,
    input  logic       baud,
    input  logic       rxrdy,
    output logic       y
);
    always_comb begin
        unique case (mf_src_e'(src))
            MF_OP2:   y = op2;
            MF_BAUD:  y = baud;
            MF_RXRDY: y = rxrdy;
            default:  y = 1'b0;
        endcase
    end
endmodule

// File: rtl/dual_bcast_frontend.sv
module dual_bcast_frontend
    import dbf_pkg::*;
#(
    parameter int DATA_W   = DATA_W_DEF,
    parameter int ADDR_W   = ADDR_W_DEF,
    parameter int CFG_ADDR = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs,
    input  logic              rd,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic              ch_sel,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic [NUM_CH-1:0] mf_out
);
    localparam logic [ADDR_W-1:0] CFG_A = ADDR_W'(CFG_ADDR);

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
    } fe_st_t;

    fe_st_t f_d, f_q;

    logic              acc_wr, acc_rd, cfg_hit, cfg_we, bcast;
    logic [1:0]        mf_src;
    logic [DATA_W-1:0] cfg_rval, rd_pick;
    logic [NUM_CH-1:0] bank_we, op2_v, baud_v, rxrdy_v;
    logic [DATA_W-1:0] bank_rd [NUM_CH];

    assign acc_wr  = cs && wr;
    assign acc_rd  = cs && rd;
    assign cfg_hit = (addr == CFG_A);
    assign cfg_we  = acc_wr && cfg_hit;

    dbf_shared_cfg #(.DATA_W(DATA_W)) cfg_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (cfg_we),
        .wdata  (wr_data),
        .bcast  (bcast),
        .mf_src (mf_src),
        .rval   (cfg_rval)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        assign bank_we[c] = acc_wr && !cfg_hit && (bcast || (ch_sel == 1'(c)));

        dbf_chan_bank #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) bank_i (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (bank_we[c]),
            .addr  (addr),
            .wdata (wr_data),
            .rdata (bank_rd[c]),
            .op2   (op2_v[c]),
            .baud  (baud_v[c]),
            .rxrdy (rxrdy_v[c])
        );

        dbf_mf_mux mux_i (
            .src   (mf_src),
            .op2   (op2_v[c]),
            .baud  (baud_v[c]),
            .rxrdy (rxrdy_v[c]),
            .y     (mf_out[c])
        );
    end

    always_comb begin
        rd_pick = cfg_hit ? cfg_rval : bank_rd[ch_sel];
        f_d     = f_q;
        if (acc_rd) begin
            f_d.rdata = rd_pick;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    assign rd_data = f_q.rdata;

    assert_rdata_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_rd |=> $stable(rd_data));

    assert_cfg_needs_cs_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(cs && wr) |=> ($stable(mf_src) && $stable(bcast)));

    assert_reserved_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mf_src == 2'b11) |-> (mf_out == '0));

    assert_bcast_both_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bcast && acc_wr && !cfg_hit) |-> (&bank_we));

    assert_single_ch_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!bcast) |-> $onehot0(bank_we));
endmodule

// File: tb/dual_bcast_frontend_tb.sv
module dual_bcast_frontend_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs = 1'b0, rd = 1'b0, wr = 1'b0, ch_sel = 1'b0;
    logic [2:0] addr = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic [1:0] mf_out;

    int checks = 0;
    int errors = 0;
    logic [7:0] exp_q [$];
    string      tag_q [$];
    bit         rd_fired = 1'b0;

    always #10 clk = ~clk;

    dual_bcast_frontend dut_i (
        .clk(clk), .rst_n(rst_n), .cs(cs), .rd(rd), .wr(wr),
        .addr(addr), .ch_sel(ch_sel), .wr_data(wr_data),
        .rd_data(rd_data), .mf_out(mf_out)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    // monitor: compares each registered read against the scoreboard
    always @(negedge clk) begin
        if (rd_fired) begin
            rd_fired = 1'b0;
            if (exp_q.size() > 0) check(tag_q.pop_front(), rd_data, exp_q.pop_front());
        end
    end

    task automatic bus_write(input logic c, input logic [2:0] a, input logic [7:0] d, input logic sel = 1'b1);
        @(negedge clk);
        cs = sel; wr = 1'b1; ch_sel = c; addr = a; wr_data = d;
        @(negedge clk);
        cs = 1'b0; wr = 1'b0;
    endtask

    task automatic bus_read(input logic c, input logic [2:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        cs = 1'b1; rd = 1'b1; ch_sel = c; addr = a;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(posedge clk);
        #1 rd_fired = 1'b1;
        @(negedge clk);
        cs = 1'b0; rd = 1'b0;
    endtask

    task automatic count_edges(input string tag);
        logic [1:0] prev;
        int n0 = 0, n1 = 0;
        @(negedge clk);
        prev = mf_out;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (mf_out[0] != prev[0]) n0++;
            if (mf_out[1] != prev[1]) n1++;
            prev = mf_out;
        end
        check({tag, " chA"}, 8'(n0), 8'd4);
        check({tag, " chB"}, 8'(n1), 8'd4);
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : stim
        logic [1:0] m0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 rd_data", rd_data, 8'h00);
        check("R1 mf_out", {6'b0, mf_out}, 8'h00);
        bus_read(1'b0, 3'd2, 8'h00, "R1 chA addr2");
        bus_read(1'b1, 3'd7, 8'h00, "R1 chB scratch");
        bus_read(1'b0, 3'd5, 8'h00, "R1 cfg");

        // R2: broadcast off, per-channel writes
        bus_write(1'b0, 3'd2, 8'hA5);
        bus_write(1'b1, 3'd2, 8'h3C);
        bus_read(1'b0, 3'd2, 8'hA5, "R2 chA keeps own");
        bus_read(1'b1, 3'd2, 8'h3C, "R2 chB keeps own");

        // R6: scratchpad per channel, no effect on mf_out
        bus_write(1'b0, 3'd7, 8'h5A);
        bus_write(1'b1, 3'd7, 8'hC3);
        check("R6 mf_out unchanged", {6'b0, mf_out}, 8'h00);
        bus_read(1'b0, 3'd7, 8'h5A, "R6 chA scratch");
        bus_read(1'b1, 3'd7, 8'hC3, "R6 chB scratch");

        // R5: shared register through channel B alias, high bits read 0
        bus_write(1'b1, 3'd5, 8'hF9);
        bus_read(1'b0, 3'd5, 8'h01, "R5 cfg via chA");
        bus_read(1'b1, 3'd5, 8'h01, "R5 cfg via chB");

        // R3: broadcast write through channel A lands in both
        bus_write(1'b0, 3'd3, 8'h77);
        bus_read(1'b1, 3'd3, 8'h77, "R3 chB got broadcast");
        bus_read(1'b0, 3'd3, 8'h77, "R3 chA got broadcast");
        // R4: reads stay channel-selected with broadcast on
        bus_read(1'b0, 3'd2, 8'hA5, "R4 chA read under bcast");
        bus_read(1'b1, 3'd2, 8'h3C, "R4 chB read under bcast");

        // R7: OP2 source
        bus_write(1'b0, 3'd4, 8'h08);
        check("R7 both op2", {6'b0, mf_out}, 8'h03);
        bus_write(1'b0, 3'd5, 8'h00);
        bus_write(1'b1, 3'd4, 8'h00);
        check("R7 chB op2 cleared", {6'b0, mf_out}, 8'h01);

        // R9: receive-ready source
        bus_write(1'b0, 3'd5, 8'h04);
        bus_write(1'b0, 3'd0, 8'h01);
        check("R9 chA ready", {6'b0, mf_out}, 8'h01);
        bus_write(1'b1, 3'd0, 8'h01);
        check("R9 both ready", {6'b0, mf_out}, 8'h03);
        bus_write(1'b0, 3'd0, 8'h00);
        check("R9 chB only", {6'b0, mf_out}, 8'h02);

        // R10: reserved code forces low
        bus_write(1'b1, 3'd5, 8'h06);
        check("R10 reserved low", {6'b0, mf_out}, 8'h00);

        // R8: baud source, divisor set by one broadcast write
        bus_write(1'b0, 3'd5, 8'h03);
        bus_write(1'b1, 3'd1, 8'h00);
        @(negedge clk);
        m0 = mf_out;
        @(negedge clk);
        check("R8 div0 toggles", {6'b0, mf_out}, {6'b0, ~m0});
        bus_write(1'b0, 3'd1, 8'h02);
        repeat (4) @(negedge clk);
        count_edges("R8 div2 toggles every 3");

        // R11: strobes without chip select
        bus_write(1'b0, 3'd2, 8'hFF, 1'b0);
        bus_write(1'b0, 3'd5, 8'h00, 1'b0);
        bus_read(1'b0, 3'd2, 8'hA5, "R11 write without cs ignored");
        bus_read(1'b1, 3'd5, 8'h03, "R11 cfg write without cs ignored");
        @(negedge clk);
        rd = 1'b1; ch_sel = 1'b0; addr = 3'd7;
        @(negedge clk);
        rd = 1'b0;
        check("R11 rd without cs holds", rd_data, 8'h03);

        repeat (3) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule